// File: doc/BRIEF.md
# Interrupt Status Register with Live Input

This block collects interrupt causes for a hardware monitor and presents them through a small register port. Most status bits are sticky. A one-cycle event pulse sets its bit, and the bit stays set until the host reads the status register. The read returns the bit and then clears it. A separate mirror address shows the same bits, and reading it clears nothing. A mask register decides which set bits drive the active-high interrupt line.

One status bit works differently. It follows a multiplexed pin that can serve as a general-purpose logic input or as the input of a second temperature sensor. A configuration bit picks the pin's role. In logic-input mode the pin passes through a synchronizer and a selectable inversion, and the result appears in the status bit as a live level that is never latched. A status read does not clear it. In sensor mode the bit is held at 0. The block has one synchronous active-low reset. Upstream logic combines the power-on reset and the bidirectional reset pin into that single input, and it returns configuration, status, mirror and mask to zero.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, configuration, mask, status and mirror all read 0x00 and `irq` is 0.
- R2: When configuration bit 7 is 1 (sensor mode), status bit 4 reads 0 and does not contribute to `irq`, whatever the pin level.
- R3: Configuration bit 6 sets polarity. When it is 0, status bit 4 equals the synchronized pin level. When it is 1, status bit 4 equals the inverted level.
- R4: In logic-input mode, status bit 4 follows the pin within SYNC_STAGES clock edges, is never latched, and is not cleared by reading the status register.
- R5: Any other status bit is set by a one-cycle high on its `evt_pulse` line. It stays set until a status read returns it, and it is 0 from the next read onward.
- R6: If an event arrives in the same cycle as a status read, the read returns the earlier value and the event's bit remains set afterwards.
- R7: The mirror address (2) returns the same bits as the status register, and reading it clears nothing.
- R8: `irq` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R9: Configuration (address 0) and mask (address 3) read back the value written. Writes to status (address 1) or mirror (address 2) have no effect, and `evt_pulse[4]` is ignored.
- R10: A read with `rd_en` high returns `rdata` on the next cycle, with `rd_valid` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on or reset pin) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 config, 1 status, 2 mirror, 3 mask |
| wdata | input | DATA_W | Write data |
| evt_pulse | input | DATA_W | One-cycle event pulses, one per status bit |
| gpi_pin | input | 1 | Asynchronous multiplexed pin level |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | DATA_W | Read data |
| irq | output | 1 | Active-high interrupt |

## Verification
A sticky bit that clears at the wrong time shows up on the next status or mirror read. It also shows up at once on `irq` when that bit is the only unmasked source. A wrong polarity or mode state in the live path changes status bit 4 and `irq` within SYNC_STAGES cycles of a pin change, and two consecutive status reads that both show bit 4 set confirm the bit is not latched. A lost event in a read-versus-event collision appears only on the following status read, so the bench always reads twice after a collision.

// File: rtl/irq_status_pkg.sv
// Package: shared register selector for the interrupt status block.
// Assumes a 2-bit register address.
package irq_status_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CFG    = 2'd0,
        REG_STATUS = 2'd1,
        REG_MIRROR = 2'd2,
        REG_MASK   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_live_input.sv
// Module: irq_live_input
// Synchronizes the asynchronous multiplexed pin, applies the polarity
// selection and forces the result to 0 in sensor mode.
// Assumes the mode and polarity controls come from flops in the same clock domain.
module irq_live_input #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic mode_sensor,
    input  logic pol_low,
    output logic live_out
);

    logic level_sync;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign level_sync = pin_async;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;

            // Shift the pin level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= pin_async;
                    for (int k = 1; k < int'(SYNC_STAGES); k++) begin
                        sync_q[k] <= sync_q[k-1];
                    end
                end
            end

            assign level_sync = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // Apply polarity and the sensor-mode override.
    always_comb begin
        live_out = (level_sync ^ pol_low) & ~mode_sensor;
    end

endmodule

// File: rtl/irq_sticky_bank.sv
// Module: irq_sticky_bank
// One sticky flop per status bit, except the live bit, which is tied to 0.
// A clear request empties every bit, but an event in the same cycle
// wins and leaves its bit set.
// Assumes events are one-cycle pulses synchronous to clk.
module irq_sticky_bank #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned LIVE_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic              clr,
    output logic [DATA_W-1:0] sticky_q
);

    generate
        for (genvar i = 0; i < int'(DATA_W); i++) begin : g_bit
            if (i == int'(LIVE_BIT)) begin : g_live
                assign sticky_q[i] = 1'b0;
            end else begin : g_sticky
                logic bit_q;

                // Set on event, clear on status read, with the event taking priority.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        bit_q <= 1'b0;
                    end else if (evt[i]) begin
                        bit_q <= 1'b1;
                    end else if (clr) begin
                        bit_q <= 1'b0;
                    end
                end

                assign sticky_q[i] = bit_q;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_reg_file.sv
// Module: irq_reg_file
// Holds the configuration and mask registers, decodes reads and writes,
// and registers the read data. Requests a clear of the sticky bits when
// the status address is read.
// Assumes at most one of wr_en and rd_en matters per cycle for a given address.
module irq_reg_file #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status_view,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              status_rd,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata
);
    import irq_status_pkg::*;

    reg_sel_e           sel;
    logic [DATA_W-1:0]  rd_mux;

    // Decode the address into a register selector.
    always_comb begin
        sel = reg_sel_e'(addr);
    end

    // Flag a status read, which clears the sticky bits.
    always_comb begin
        status_rd = rd_en && (sel == REG_STATUS);
    end

    // Pick the read source; status and mirror show the same bits.
    always_comb begin
        unique case (sel)
            REG_CFG:    rd_mux = cfg_q;
            REG_STATUS: rd_mux = status_view;
            REG_MIRROR: rd_mux = status_view;
            REG_MASK:   rd_mux = mask_q;
            default:    rd_mux = '0;
        endcase
    end

    // Update the writable registers; status and mirror ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (sel == REG_CFG)  cfg_q  <= wdata;
            if (sel == REG_MASK) mask_q <= wdata;
        end
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_status_unit.sv
// Module: irq_status_unit (top)
// Interrupt status block. Sticky event bits plus one live pin bit, a
// read-only mirror, a mask and an active-high interrupt.
// Assumes rst_n already merges the power-on and bidirectional-pin resets.
module irq_status_unit #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned LIVE_BIT    = 4,
    parameter int unsigned MODE_BIT    = 7,
    parameter int unsigned POL_BIT     = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt_pulse,
    input  logic              gpi_pin,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] sticky_q;
    logic [DATA_W-1:0] status_view;
    logic              status_rd;
    logic              live_bit;

    irq_live_input #(.SYNC_STAGES(SYNC_STAGES)) u_live (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_async   (gpi_pin),
        .mode_sensor (cfg_q[MODE_BIT]),
        .pol_low     (cfg_q[POL_BIT]),
        .live_out    (live_bit)
    );

    irq_sticky_bank #(.DATA_W(DATA_W), .LIVE_BIT(LIVE_BIT)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .clr      (status_rd),
        .sticky_q (sticky_q)
    );

    irq_reg_file #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .status_view (status_view),
        .cfg_q       (cfg_q),
        .mask_q      (mask_q),
        .status_rd   (status_rd),
        .rd_valid    (rd_valid),
        .rdata       (rdata)
    );

    // Merge the sticky bits with the live pin bit.
    always_comb begin
        status_view           = sticky_q;
        status_view[LIVE_BIT] = live_bit;
    end

    // Raise the interrupt for any unmasked set status bit.
    always_comb begin
        irq = |(status_view & ~mask_q);
    end

endmodule

// File: rtl/irq_status_checker.sv
// Module: irq_status_checker
// Protocol and state assertions for irq_status_unit, attached by bind.
module irq_status_checker #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned LIVE_BIT = 4,
    parameter int unsigned MODE_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] evt_pulse,
    input logic [DATA_W-1:0] sticky_q,
    input logic [DATA_W-1:0] status_view,
    input logic [DATA_W-1:0] cfg_q,
    input logic [DATA_W-1:0] mask_q,
    input logic              rd_valid,
    input logic              irq
);
    import irq_status_pkg::*;

    localparam logic [DATA_W-1:0] LIVE_MASK = DATA_W'(1) << LIVE_BIT;

    logic              stat_read;
    logic [DATA_W-1:0] evt_eff;

    always_comb begin
        stat_read = rd_en && (addr == REG_STATUS);
        evt_eff   = evt_pulse & ~LIVE_MASK;
    end

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);                                                          // R10
    AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);                                                        // R10
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_read |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));            // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_eff) |=> ((sticky_q & $past(evt_eff)) == $past(evt_eff)));             // R6
    AST_SENSOR_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[MODE_BIT] |-> !status_view[LIVE_BIT]);                                  // R2
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);                                                          // R8
    AST_NONE_SET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status_view == '0) |-> !irq);                                                // R8

endmodule

bind irq_status_unit irq_status_checker #(
    .DATA_W   (DATA_W),
    .LIVE_BIT (LIVE_BIT),
    .MODE_BIT (MODE_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .addr        (addr),
    .evt_pulse   (evt_pulse),
    .sticky_q    (sticky_q),
    .status_view (status_view),
    .cfg_q       (cfg_q),
    .mask_q      (mask_q),
    .rd_valid    (rd_valid),
    .irq         (irq)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] evt_pulse = '0;
    logic         gpi_pin = 1'b0;
    logic         rd_valid;
    logic [W-1:0] rdata;
    logic         irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    localparam logic [1:0] A_CFG = 2'd0, A_STAT = 2'd1, A_MIR = 2'd2, A_MASK = 2'd3;

    irq_status_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .evt_pulse(evt_pulse), .gpi_pin(gpi_pin),
        .rd_valid(rd_valid), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per read response.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected rd_valid", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_write(logic [1:0] a, logic [W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [1:0] a, logic [W-1:0] exp, string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(logic [W-1:0] e);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic set_pin(logic v);
        gpi_pin = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        apply_reset();
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        do_read(A_CFG, 8'h00, "R1 cfg reset");
        do_read(A_MASK, 8'h00, "R1 mask reset");
        do_read(A_STAT, 8'h00, "R1 status reset");
        do_read(A_MIR, 8'h00, "R1 mirror reset");
        @(negedge clk);
        check("R10 rd_valid single cycle", {7'd0, rd_valid}, 8'h00);

        // Register access
        do_write(A_MASK, 8'hA5);
        do_read(A_MASK, 8'hA5, "R9 mask readback");
        do_write(A_CFG, 8'h2B);
        do_read(A_CFG, 8'h2B, "R9 cfg readback");
        do_write(A_CFG, 8'h00);
        do_write(A_MASK, 8'h00);
        do_write(A_STAT, 8'hFF);
        do_write(A_MIR, 8'hFF);
        do_read(A_STAT, 8'h00, "R9 status write ignored");

        // Sticky events and mirror
        pulse(8'h05);
        check("R8 irq on event", {7'd0, irq}, 8'h01);
        do_read(A_MIR, 8'h05, "R7 mirror read");
        do_read(A_MIR, 8'h05, "R7 mirror no clear");
        do_read(A_STAT, 8'h05, "R5 status returns events");
        do_read(A_STAT, 8'h00, "R5 status cleared");
        check("R8 irq clear", {7'd0, irq}, 8'h00);

        // Event coincident with status read
        pulse(8'h01);
        evt_pulse = 8'h02; rd_en = 1'b1; addr = A_STAT;
        exp_q.push_back(8'h01); tag_q.push_back("R6 collision read");
        @(negedge clk);
        evt_pulse = '0; rd_en = 1'b0;
        do_read(A_STAT, 8'h02, "R6 event survives read");
        do_read(A_STAT, 8'h00, "R6 cleared after");

        // Live bit, active high
        set_pin(1'b1);
        do_read(A_STAT, 8'h10, "R4 live set");
        do_read(A_STAT, 8'h10, "R4 live not cleared");
        check("R4 irq from live", {7'd0, irq}, 8'h01);
        set_pin(1'b0);
        do_read(A_STAT, 8'h00, "R4 live follows low");
        check("R4 irq low", {7'd0, irq}, 8'h00);

        // Polarity inversion
        do_write(A_CFG, 8'h40);
        repeat (2) @(negedge clk);
        do_read(A_STAT, 8'h10, "R3 active low pin 0");
        set_pin(1'b1);
        do_read(A_STAT, 8'h00, "R3 active low pin 1");

        // Sensor mode
        do_write(A_CFG, 8'hC0);
        set_pin(1'b0);
        do_read(A_STAT, 8'h00, "R2 sensor mode inverted");
        check("R2 irq sensor mode", {7'd0, irq}, 8'h00);
        do_write(A_CFG, 8'h80);
        set_pin(1'b1);
        do_read(A_STAT, 8'h00, "R2 sensor mode pin high");
        check("R2 irq sensor high", {7'd0, irq}, 8'h00);

        // Masking
        do_write(A_CFG, 8'h00);
        set_pin(1'b0);
        pulse(8'h08);
        do_write(A_MASK, 8'h08);
        check("R8 masked event", {7'd0, irq}, 8'h00);
        do_write(A_MASK, 8'hF7);
        check("R8 unmasked event", {7'd0, irq}, 8'h01);
        do_read(A_STAT, 8'h08, "R5 masked bit still latched");
        do_write(A_MASK, 8'h10);
        set_pin(1'b1);
        check("R8 live masked", {7'd0, irq}, 8'h00);
        do_write(A_MASK, 8'h00);
        check("R8 live unmasked", {7'd0, irq}, 8'h01);
        set_pin(1'b0);

        // Event on live bit ignored
        pulse(8'h10);
        do_read(A_STAT, 8'h00, "R9 live event ignored");

        // Reset mid-operation
        do_write(A_CFG, 8'hC0);
        do_write(A_MASK, 8'h3C);
        pulse(8'h81);
        apply_reset();
        do_read(A_CFG, 8'h00, "R1 cfg after re-reset");
        do_read(A_MASK, 8'h00, "R1 mask after re-reset");
        do_read(A_STAT, 8'h00, "R1 status after re-reset");
        check("R1 irq after re-reset", {7'd0, irq}, 8'h00);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R10 missing responses", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule